// File: doc/BRIEF.md
# Display Transmitter Control Target with DDC Handshake

This block is an I2C target that stands in for the control port of a display transmitter. A bus controller addresses it at a fixed 7-bit device address. Each write transfer begins with a byte that sets an internal register pointer. Any further data bytes are written at that pointer, and the pointer moves on by one after each byte. Reads return bytes from the pointer onward and also advance it.

Only three offsets carry content. The identifier offset returns a constant. The interrupt-status offset always reports that a sink is attached and that no hotplug event is waiting. The system-control offset does not store what is written to it. It holds a two-step handshake for the DDC bus instead: a request, and optionally a grant. While the block is in DDC mode it raises the `ddc_mode` output, so that neighbouring logic can route the display data channel.

SCL and SDA come in as raw pad levels and are resynchronised to the system clock. SDA is driven open-drain: `sda_oe` high pulls the line low.

Top module: `i2c_dispctl_target`

## Requirements
- R1: Only an address byte whose upper seven bits equal DEV_ADDR (default 0x39) is acknowledged. A transfer to any other address gets no ACK and changes no state.
- R2: In a write transfer, the byte after the address is loaded into the register pointer rather than written. Every byte written to the matching address is acknowledged.
- R3: The pointer increments by one after every data byte read and after every data byte written, including bytes at unimplemented offsets.
- R4: Reading offset 0x1B returns 0xB0.
- R5: Reading offset 0x3D returns 0x04 (sink present, no pending event).
- R6: Writing offset 0x1A with bit 2 (request) set sets the request flag. If bit 1 (grant) is also set in that byte, `ddc_mode` goes high. A request-only byte leaves `ddc_mode` unchanged.
- R7: Writing offset 0x1A with bit 2 clear clears both the request flag and `ddc_mode`, whatever bit 1 holds.
- R8: Reading offset 0x1A returns 0x06 while the request flag is set, and 0x00 otherwise.
- R9: Every other offset reads 0x00, and writes to those offsets have no effect beyond advancing the pointer.
- R10: Synchronous reset clears the pointer, the request flag, `ddc_mode` and the pending-pointer flag, and releases SDA.
- R11: A START followed by a read transfer starts reading at the current pointer, so a pointer write followed by a read returns the addressed register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Raw SCL level from the pad |
| sda_in | input | 1 | Raw SDA level from the pad |
| sda_oe | output | 1 | Registered open-drain enable; high pulls SDA low |
| ddc_mode | output | 1 | Registered flag, high while DDC mode is granted |

## Verification
The bench instantiates the block with DEV_ADDR at 0x39 and SYNC_STAGES at 3, one more stage than the default. The extra stage stretches the delay from a pad edge to the internal edge strobes. This lets the bench confirm that ACK and read bits are still placed and released within the low half of SCL. Because the address is the default, a neighbouring address (0x3A) serves as the mismatch case. The DDC handshake is driven through request-only, request-plus-grant and grant-only bytes, with a mid-run reset that must return the pointer to offset 0.

// File: rtl/dctl_pkg.sv
package dctl_pkg;

  localparam logic [7:0] OFS_SYSCTL  = 8'h1A;
  localparam logic [7:0] OFS_IDENT   = 8'h1B;
  localparam logic [7:0] OFS_IRQSTAT = 8'h3D;

  localparam logic [7:0] IDENT_VAL   = 8'hB0;
  localparam logic [7:0] IRQSTAT_VAL = 8'h04;

  localparam int BIT_REQ = 2;
  localparam int BIT_GNT = 1;

  localparam logic [7:0] SYSCTL_GRANTED = (8'h1 << BIT_REQ) | (8'h1 << BIT_GNT);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_WDATA,
    ST_WACK,
    ST_RDATA,
    ST_RACK
  } tgt_state_t;

endpackage

// File: rtl/dctl_line_sync.sv
module dctl_line_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_raw,
  input  logic sda_raw,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);

  logic [SYNC_STAGES-1:0] scl_p;
  logic [SYNC_STAGES-1:0] sda_p;
  logic scl_d, sda_d;
  logic scl_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_p <= '1;
      sda_p <= '1;
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_p <= {scl_p[SYNC_STAGES-2:0], scl_raw};
      sda_p <= {sda_p[SYNC_STAGES-2:0], sda_raw};
      scl_d <= scl_p[SYNC_STAGES-1];
      sda_d <= sda_p[SYNC_STAGES-1];
    end
  end

  assign scl_s     = scl_p[SYNC_STAGES-1];
  assign sda_s     = sda_p[SYNC_STAGES-1];
  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;
  assign start_det = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;

endmodule

// File: rtl/dctl_bit_engine.sv
module dctl_bit_engine
  import dctl_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h39
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       sda_s,
  input  logic       scl_rise,
  input  logic       scl_fall,
  input  logic       start_det,
  input  logic       stop_det,
  input  logic [7:0] rd_byte,
  output logic       sda_oe,
  output logic       wr_begin,
  output logic       wr_stb,
  output logic [7:0] wr_byte,
  output logic       rd_stb,
  output logic       idle_o
);

  localparam int CNT_W = 4;
  localparam logic [CNT_W-1:0] BYTE_BITS = CNT_W'(8);

  tgt_state_t       state;
  logic [CNT_W-1:0] cnt;
  logic [7:0]       sh;
  logic [7:0]       tx;
  logic             rw;
  logic             mack;

  always_ff @(posedge clk) begin
    wr_stb   <= 1'b0;
    rd_stb   <= 1'b0;
    wr_begin <= 1'b0;
    if (rst) begin
      state  <= ST_IDLE;
      sda_oe <= 1'b0;
      cnt    <= '0;
      sh     <= '0;
      tx     <= '0;
      rw     <= 1'b0;
      mack   <= 1'b0;
    end else if (start_det) begin
      state  <= ST_ADDR;
      cnt    <= '0;
      sda_oe <= 1'b0;
    end else if (stop_det) begin
      state  <= ST_IDLE;
      sda_oe <= 1'b0;
    end else begin
      case (state)
        ST_ADDR: begin
          if (scl_rise && cnt < BYTE_BITS) begin
            sh  <= {sh[6:0], sda_s};
            cnt <= cnt + 1'b1;
          end else if (scl_fall && cnt == BYTE_BITS) begin
            if (sh[7:1] == DEV_ADDR) begin
              sda_oe <= 1'b1;
              rw     <= sh[0];
              state  <= ST_ADDR_ACK;
            end else begin
              state <= ST_IDLE;
            end
          end
        end
        ST_ADDR_ACK: begin
          if (scl_fall) begin
            cnt <= '0;
            if (rw) begin
              tx     <= rd_byte;
              rd_stb <= 1'b1;
              sda_oe <= ~rd_byte[7];
              state  <= ST_RDATA;
            end else begin
              sda_oe   <= 1'b0;
              wr_begin <= 1'b1;
              state    <= ST_WDATA;
            end
          end
        end
        ST_WDATA: begin
          if (scl_rise && cnt < BYTE_BITS) begin
            sh  <= {sh[6:0], sda_s};
            cnt <= cnt + 1'b1;
          end else if (scl_fall && cnt == BYTE_BITS) begin
            sda_oe <= 1'b1;
            wr_stb <= 1'b1;
            state  <= ST_WACK;
          end
        end
        ST_WACK: begin
          if (scl_fall) begin
            sda_oe <= 1'b0;
            cnt    <= '0;
            state  <= ST_WDATA;
          end
        end
        ST_RDATA: begin
          if (scl_rise && cnt < BYTE_BITS) begin
            cnt <= cnt + 1'b1;
          end else if (scl_fall) begin
            if (cnt == BYTE_BITS) begin
              sda_oe <= 1'b0;
              state  <= ST_RACK;
            end else begin
              tx     <= {tx[6:0], 1'b0};
              sda_oe <= ~tx[6];
            end
          end
        end
        ST_RACK: begin
          if (scl_rise) begin
            mack <= ~sda_s;
          end else if (scl_fall) begin
            if (mack) begin
              tx     <= rd_byte;
              rd_stb <= 1'b1;
              sda_oe <= ~rd_byte[7];
              cnt    <= '0;
              state  <= ST_RDATA;
            end else begin
              state <= ST_IDLE;
            end
          end
        end
        default: begin
          sda_oe <= 1'b0;
        end
      endcase
    end
  end

  assign wr_byte = sh;
  assign idle_o  = (state == ST_IDLE);

endmodule

// File: rtl/dctl_regs.sv
module dctl_regs
  import dctl_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_begin,
  input  logic       wr_stb,
  input  logic [7:0] wr_byte,
  input  logic       rd_stb,
  output logic [7:0] rd_byte,
  output logic       ddc_mode,
  output logic       req_o,
  output logic [7:0] ptr_o
);

  logic [7:0] ptr_q;
  logic       pend_q;
  logic       req_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_q    <= '0;
      pend_q   <= 1'b0;
      req_q    <= 1'b0;
      ddc_mode <= 1'b0;
    end else if (wr_begin) begin
      pend_q <= 1'b1;
    end else if (wr_stb) begin
      if (pend_q) begin
        ptr_q  <= wr_byte;
        pend_q <= 1'b0;
      end else begin
        ptr_q <= ptr_q + 8'd1;
        if (ptr_q == OFS_SYSCTL) begin
          if (wr_byte[BIT_REQ]) begin
            req_q <= 1'b1;
            if (wr_byte[BIT_GNT]) ddc_mode <= 1'b1;
          end else begin
            req_q    <= 1'b0;
            ddc_mode <= 1'b0;
          end
        end
      end
    end else if (rd_stb) begin
      ptr_q <= ptr_q + 8'd1;
    end
  end

  always_comb begin
    case (ptr_q)
      OFS_SYSCTL:  rd_byte = req_q ? SYSCTL_GRANTED : 8'h00;
      OFS_IDENT:   rd_byte = IDENT_VAL;
      OFS_IRQSTAT: rd_byte = IRQSTAT_VAL;
      default:     rd_byte = 8'h00;
    endcase
  end

  assign req_o = req_q;
  assign ptr_o = ptr_q;

endmodule

// File: rtl/i2c_dispctl_target.sv
module i2c_dispctl_target #(
  parameter logic [6:0] DEV_ADDR    = 7'h39,
  parameter int         SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_in,
  input  logic sda_in,
  output logic sda_oe,
  output logic ddc_mode
);

  logic       sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic [7:0] rd_byte, wr_byte, ptr_q;
  logic       wr_begin, wr_stb, rd_stb, fsm_idle, req_flag;

  dctl_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst       (rst),
    .scl_raw   (scl_in),
    .sda_raw   (sda_in),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  dctl_bit_engine #(.DEV_ADDR(DEV_ADDR)) u_engine (
    .clk       (clk),
    .rst       (rst),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det),
    .rd_byte   (rd_byte),
    .sda_oe    (sda_oe),
    .wr_begin  (wr_begin),
    .wr_stb    (wr_stb),
    .wr_byte   (wr_byte),
    .rd_stb    (rd_stb),
    .idle_o    (fsm_idle)
  );

  dctl_regs u_regs (
    .clk      (clk),
    .rst      (rst),
    .wr_begin (wr_begin),
    .wr_stb   (wr_stb),
    .wr_byte  (wr_byte),
    .rd_stb   (rd_stb),
    .rd_byte  (rd_byte),
    .ddc_mode (ddc_mode),
    .req_o    (req_flag),
    .ptr_o    (ptr_q)
  );

endmodule

// File: rtl/dctl_checker.sv
module dctl_checker (
  input logic       clk,
  input logic       rst,
  input logic       sda_oe,
  input logic       ddc_mode,
  input logic       req_flag,
  input logic [7:0] ptr_q,
  input logic       rd_stb,
  input logic       wr_stb,
  input logic       fsm_idle
);

  assert_reset_release_R10: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!sda_oe && !ddc_mode && !req_flag && ptr_q == 8'h00));

  assert_mode_needs_req_R6: assert property (@(posedge clk) disable iff (rst)
    ddc_mode |-> req_flag);

  assert_mode_only_on_write_R7: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$stable(ddc_mode)) |-> $past(wr_stb));

  assert_ptr_step_read_R3: assert property (@(posedge clk) disable iff (rst)
    rd_stb |=> (ptr_q == $past(ptr_q) + 8'd1));

  assert_idle_no_drive_R1: assert property (@(posedge clk) disable iff (rst)
    fsm_idle |-> !sda_oe);

endmodule

bind i2c_dispctl_target dctl_checker u_chk (
  .clk      (clk),
  .rst      (rst),
  .sda_oe   (sda_oe),
  .ddc_mode (ddc_mode),
  .req_flag (req_flag),
  .ptr_q    (ptr_q),
  .rd_stb   (rd_stb),
  .wr_stb   (wr_stb),
  .fsm_idle (fsm_idle)
);

// File: tb/test_i2c_dispctl_target.sv
module test_i2c_dispctl_target;

  localparam int Q = 10;
  localparam logic [6:0] ADDR = 7'h39;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic sda_oe, ddc_mode;
  logic sda_line;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;
  logic [7:0] rdbuf [0:31];

  always #5 clk = ~clk;

  assign sda_line = sda_m & ~sda_oe;

  i2c_dispctl_target #(.DEV_ADDR(ADDR), .SYNC_STAGES(3)) i_i2c_dispctl_target (
    .clk      (clk),
    .rst      (rst),
    .scl_in   (scl_m),
    .sda_in   (sda_line),
    .sda_oe   (sda_oe),
    .ddc_mode (ddc_mode)
  );

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  task automatic start_cond();
    sda_m = 1'b1; wt(Q);
    scl_m = 1'b1; wt(Q);
    sda_m = 1'b0; wt(Q);
    scl_m = 1'b0; wt(Q);
  endtask

  task automatic stop_cond();
    sda_m = 1'b0; wt(Q);
    scl_m = 1'b1; wt(Q);
    sda_m = 1'b1; wt(Q);
  endtask

  task automatic send_bit(input logic b);
    sda_m = b; wt(Q);
    scl_m = 1'b1; wt(2*Q);
    scl_m = 1'b0; wt(Q);
  endtask

  task automatic recv_bit(output logic b);
    sda_m = 1'b1; wt(Q);
    scl_m = 1'b1; wt(Q);
    b = sda_line; wt(Q);
    scl_m = 1'b0; wt(Q);
  endtask

  task automatic write_byte(input logic [7:0] d, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) send_bit(d[i]);
    recv_bit(b);
    ack = ~b;
  endtask

  task automatic read_byte(input logic last, output logic [7:0] d);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      recv_bit(b);
      d[i] = b;
    end
    send_bit(last);
  endtask

  // Write pointer then data bytes; returns AND of all ACKs
  task automatic reg_write(input logic [7:0] ptr, input logic [7:0] d0,
                           input logic [7:0] d1, input int n, output logic all_ack);
    logic a;
    all_ack = 1'b1;
    start_cond();
    write_byte({ADDR, 1'b0}, a); all_ack &= a;
    write_byte(ptr, a);          all_ack &= a;
    if (n > 0) begin write_byte(d0, a); all_ack &= a; end
    if (n > 1) begin write_byte(d1, a); all_ack &= a; end
    stop_cond();
  endtask

  task automatic read_cur(input int n, output logic addr_ack);
    start_cond();
    write_byte({ADDR, 1'b1}, addr_ack);
    for (int i = 0; i < n; i++) read_byte(i == n - 1, rdbuf[i]);
    stop_cond();
  endtask

  task automatic read_regs(input logic [7:0] ptr, input int n, output logic ok);
    logic a;
    ok = 1'b1;
    start_cond();
    write_byte({ADDR, 1'b0}, a); ok &= a;
    write_byte(ptr, a);          ok &= a;
    start_cond();
    write_byte({ADDR, 1'b1}, a); ok &= a;
    for (int i = 0; i < n; i++) read_byte(i == n - 1, rdbuf[i]);
    stop_cond();
  endtask

  task automatic t_reset();
    check("R10 sda_oe after reset", {7'b0, sda_oe}, 8'h00);
    check("R10 ddc_mode after reset", {7'b0, ddc_mode}, 8'h00);
  endtask

  task automatic t_ident();
    logic ok;
    read_regs(8'h1B, 1, ok);
    check("R1 address ACK", {7'b0, ok}, 8'h01);
    check("R4 ident", rdbuf[0], 8'hB0);
  endtask

  task automatic t_irqstat();
    logic ok;
    read_regs(8'h3D, 1, ok);
    check("R5 irq status", rdbuf[0], 8'h04);
  endtask

  task automatic t_sysctl_clear();
    logic ok;
    read_regs(8'h1A, 1, ok);
    check("R8 sysctl without request", rdbuf[0], 8'h00);
  endtask

  task automatic t_request_only();
    logic ok;
    reg_write(8'h1A, 8'h04, 8'h00, 1, ok);
    check("R2 write ACKs", {7'b0, ok}, 8'h01);
    check("R6 request only keeps mode low", {7'b0, ddc_mode}, 8'h00);
    read_regs(8'h1A, 1, ok);
    check("R8 sysctl with request", rdbuf[0], 8'h06);
  endtask

  task automatic t_enter_ddc();
    logic ok;
    reg_write(8'h1A, 8'h06, 8'h00, 1, ok);
    check("R6 request+grant enters mode", {7'b0, ddc_mode}, 8'h01);
  endtask

  task automatic t_burst_read();
    logic ok;
    read_regs(8'h1A, 3, ok);
    check("R3 burst byte0", rdbuf[0], 8'h06);
    check("R3 burst byte1", rdbuf[1], 8'hB0);
    check("R3 burst byte2", rdbuf[2], 8'h00);
  endtask

  task automatic t_leave_ddc();
    logic ok;
    reg_write(8'h1A, 8'h02, 8'h00, 1, ok);
    check("R7 grant without request leaves mode", {7'b0, ddc_mode}, 8'h00);
    read_regs(8'h1A, 1, ok);
    check("R7 request flag cleared", rdbuf[0], 8'h00);
  endtask

  task automatic t_write_increment();
    logic ok;
    reg_write(8'h19, 8'hFF, 8'h06, 2, ok);
    check("R2 burst write ACKs", {7'b0, ok}, 8'h01);
    check("R3 second write lands at 0x1A", {7'b0, ddc_mode}, 8'h01);
    read_regs(8'h19, 1, ok);
    check("R9 unimplemented write ignored", rdbuf[0], 8'h00);
  endtask

  task automatic t_other_offsets();
    logic ok;
    read_regs(8'h3C, 2, ok);
    check("R9 offset 0x3C", rdbuf[0], 8'h00);
    check("R3 next offset 0x3D", rdbuf[1], 8'h04);
  endtask

  task automatic t_wrong_addr();
    logic a0, a1;
    start_cond();
    write_byte({7'h3A, 1'b0}, a0);
    write_byte(8'h1A, a1);
    write_byte(8'h00, a1);
    stop_cond();
    check("R1 mismatch not ACKed", {7'b0, a0}, 8'h00);
    check("R1 mismatch no state change", {7'b0, ddc_mode}, 8'h01);
  endtask

  task automatic t_pointer_kept();
    logic ok;
    reg_write(8'h3D, 8'h00, 8'h00, 0, ok);
    read_cur(1, ok);
    check("R11 read after pointer write", rdbuf[0], 8'h04);
  endtask

  task automatic t_mid_reset();
    logic ok;
    wt(2);
    rst = 1'b1; wt(3); rst = 1'b0; wt(2);
    check("R10 mode cleared by reset", {7'b0, ddc_mode}, 8'h00);
    read_cur(28, ok);
    check("R10 pointer from 0, byte 26", rdbuf[26], 8'h06 & 8'h00);
    check("R10 pointer from 0, byte 27", rdbuf[27], 8'hB0);
  endtask

  initial begin
    wt(5);
    rst = 1'b0;
    wt(5);
    t_reset();
    t_ident();
    t_irqstat();
    t_sysctl_clear();
    t_request_only();
    t_enter_ddc();
    t_burst_read();
    t_leave_ddc();
    t_write_increment();
    t_other_offsets();
    t_wrong_addr();
    t_pointer_kept();
    t_mid_reset();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  end

endmodule